// File: doc/BRIEF.md
# BF16 Matrix Tile Multiply-Accumulate

The block takes one 128-bit tile of each of two BF16 source operands and one 128-bit tile of FP32 accumulator, and returns the updated accumulator tile. The first source is read as a 2×4 BF16 matrix and the second as a 4×2 BF16 matrix. Their product is added into a 2×2 FP32 matrix. Each result element gets two 2-way dot products, and each dot product pairs adjacent BF16 elements along the shared dimension.

A mode input picks the summation style. In unfused mode every BF16 product is rounded to FP32, the pair sum is rounded, and the accumulation is rounded, all with round-to-odd. In fused mode the two products of a pair are summed exactly, and only that sum and the accumulation are rounded, with round-to-nearest-even. Denormals are flushed to zero in both modes. Any NaN outcome becomes the default NaN, and no exception state is kept.

One combinational add-and-round unit does every rounding step in sequence. Tiles move through a valid/ready handshake, one tile at a time.

Top module: `bf16_tile_mac`

## Requirements
- R1: BF16 element i sits in bits [16i+15:16i] of a source and FP32 element i in bits [32i+31:32i] of the accumulator and result. A[r][k] is first-source element 4r+k, B[k][c] is second-source element 4c+k, and C[r][c] is element 2r+c, with r, c in 0..1 and k in 0..3.
- R2: When every intermediate value is exactly representable, C[r][c] becomes C[r][c] + sum over k of A[r][k]·B[k][c], in both modes.
- R3: With in_fused = 0, each product is rounded to FP32 before the pair sum, and every rounding is round-to-odd: an inexact result is truncated and then has bit 0 forced to 1.
- R4: With in_fused = 1, the two products of a pair are added without intermediate rounding. The pair sum and the accumulation round to nearest, ties to even.
- R5: A BF16 input with exponent field 0 and an FP32 accumulator input with exponent field 0 count as zero of the same sign. A result below the smallest normal magnitude becomes a zero of the result's sign. No output lane ever holds a denormal.
- R6: A result whose magnitude overflows FP32 becomes infinity of its sign (0x7F800000 or 0xFF800000).
- R7: Any NaN outcome is written as 0x7FC00000. This covers a NaN input, infinity times zero, and the sum of opposite infinities.
- R8: An exact cancellation of nonzero values gives +0. A sum of two negative zeros gives −0 (0x80000000).
- R9: in_ready is high only when no tile is held or being computed, and a tile is taken on a clock edge with in_valid and in_ready both high. While out_valid is high and out_ready low, out_valid and out_res stay unchanged. In-port activity while busy has no effect. After the edge with out_valid and out_ready both high, the block is idle again.
- R10: out_valid rises exactly 32 clock edges after the accepting edge in unfused mode, and 16 in fused mode.
- R11: For each element, the rounded sum of pair k = 0,1 is added to the accumulator and rounded first. The rounded sum of pair k = 2,3 is then added to that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Tile offered |
| in_ready | output | 1 | Block idle, tile can be taken |
| in_fused | input | 1 | 1 = fused pair sums, 0 = unfused |
| in_a | input | 128 | First source, eight BF16 (2×4) |
| in_b | input | 128 | Second source, eight BF16 (4×2) |
| in_acc | input | 128 | Accumulator, four FP32 (2×2) |
| out_valid | output | 1 | Result tile held |
| out_ready | input | 1 | Result consumed |
| out_res | output | 128 | Updated accumulator, four FP32 |

## Verification
Two things can coincide in one cycle: a new tile offered on the input while a finished tile waits on an output that is not yet released. The bench holds in_valid high with inverted data and an inverted mode bit through the whole computation and through a held-result window with out_ready low. It then checks that the result matches the first tile, that out_res does not move during the window, and that the latency follows the first tile's mode. After release it checks that the block comes back idle, ready for the next tile.

// File: rtl/bf16_tile_mac.sv
module bf16_tile_mac #(
  parameter int SEG_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_fused,
  input  logic [SEG_W-1:0] in_a,
  input  logic [SEG_W-1:0] in_b,
  input  logic [SEG_W-1:0] in_acc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SEG_W-1:0] out_res
);
  localparam int HW = 16;
  localparam int FW = 32;
  localparam int NH = SEG_W / HW;
  localparam int NF = SEG_W / FW;
  localparam int AW = 56;
  localparam logic [FW-1:0] QNAN = 32'h7FC00000;

  typedef enum logic [1:0] {IDLE, RUN, DONE} state_t;
  typedef struct packed {
    logic        nan;
    logic        inf;
    logic        zero;
    logic        sgn;
    logic [11:0] e;
    logic [23:0] sig;
  } opnd_t;

  state_t                st;
  logic                  fused_q;
  logic [NH-1:0][HW-1:0] a_q, b_q;
  logic [NF-1:0][FW-1:0] res_q;
  logic [FW-1:0]         w0, w1, rw;
  logic [1:0]            elem, ph;
  logic                  half;
  opnd_t                 p0, p1, x, y;

  function automatic opnd_t mulop(input logic [HW-1:0] a, input logic [HW-1:0] b);
    opnd_t o;
    logic na, nb, ia, ib, za, zb;
    logic [15:0] m;
    na = (a[14:7] == 8'hFF) && (a[6:0] != 7'd0);
    nb = (b[14:7] == 8'hFF) && (b[6:0] != 7'd0);
    ia = (a[14:7] == 8'hFF) && (a[6:0] == 7'd0);
    ib = (b[14:7] == 8'hFF) && (b[6:0] == 7'd0);
    za = (a[14:7] == 8'h00);
    zb = (b[14:7] == 8'h00);
    m = {8'd1, a[6:0]} * {8'd1, b[6:0]};
    o.sgn  = a[15] ^ b[15];
    o.nan  = na | nb | (ia & zb) | (za & ib);
    o.inf  = !o.nan & (ia | ib);
    o.zero = !o.nan & !o.inf & (za | zb);
    o.e    = {4'd0, a[14:7]} + {4'd0, b[14:7]} - 12'd126;
    o.sig  = {m, 8'd0};
    return o;
  endfunction

  function automatic opnd_t fpop(input logic [FW-1:0] w);
    opnd_t o;
    o.sgn  = w[31];
    o.nan  = (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
    o.inf  = (w[30:23] == 8'hFF) && (w[22:0] == 23'd0);
    o.zero = (w[30:23] == 8'h00);
    o.e    = {4'd0, w[30:23]};
    o.sig  = {1'b1, w[22:0]};
    return o;
  endfunction

  function automatic opnd_t zop(input logic s);
    opnd_t o;
    o = '0;
    o.zero = 1'b1;
    o.sgn  = s;
    return o;
  endfunction

  assign p0 = mulop(a_q[{elem[1], half, 1'b0}], b_q[{elem[0], half, 1'b0}]);
  assign p1 = mulop(a_q[{elem[1], half, 1'b1}], b_q[{elem[0], half, 1'b1}]);

  always_comb begin
    case (ph)
      2'd0:    begin x = p0; y = zop(p0.sgn); end
      2'd1:    begin x = p1; y = zop(p1.sgn); end
      2'd2:    begin x = fused_q ? p0 : fpop(w0); y = fused_q ? p1 : fpop(w1); end
      default: begin x = fpop(res_q[elem]); y = fpop(w0); end
    endcase
  end

  opnd_t                bg, sm;
  logic signed [11:0]   d, er;
  logic [AW-1:0]        bw, full, sw, tot, sn;
  logic [AW:0]          diff;
  logic [23:0]          sg;
  logic [24:0]          sr;
  logic                 g, stk, rs;
  int                   p;

  always_comb begin
    rw = '0; bg = x; sm = y; d = '0; er = '0; bw = '0; full = '0; sw = '0;
    tot = '0; sn = '0; diff = '0; sg = '0; sr = '0; g = 1'b0; stk = 1'b0;
    rs = 1'b0; p = 0;
    if (x.nan || y.nan || (x.inf && y.inf && (x.sgn != y.sgn))) begin
      rw = QNAN;
    end else if (x.inf || y.inf) begin
      rw = {x.inf ? x.sgn : y.sgn, 8'hFF, 23'd0};
    end else if (x.zero && y.zero) begin
      rw = {x.sgn & y.sgn, 31'd0};
    end else begin
      if (x.zero || (!y.zero && ($signed(y.e) > $signed(x.e)))) begin
        bg = y; sm = x;
      end
      d    = $signed(bg.e) - $signed(sm.e);
      bw   = {1'b0, bg.sig, 31'd0};
      full = {1'b0, sm.sig, 31'd0};
      if (sm.zero)
        sw = '0;
      else if (d > 12'sd55)
        sw = 56'd1;
      else
        sw = (full >> d[5:0]) | {55'd0, |(full & ((56'd1 << d[5:0]) - 56'd1))};
      rs = bg.sgn;
      if (bg.sgn == sm.sgn) begin
        tot = bw + sw;
      end else begin
        diff = {1'b0, bw} - {1'b0, sw};
        if (diff[AW]) begin
          tot = sw - bw;
          rs  = !rs;
        end else begin
          tot = diff[AW-1:0];
        end
      end
      if (tot == '0) begin
        rw = '0;
      end else begin
        for (int i = 0; i < AW; i++)
          if (tot[i]) p = i;
        sn  = tot << (AW - 1 - p);
        sg  = sn[55:32];
        g   = sn[31];
        stk = |sn[30:0];
        er  = $signed(bg.e) + $signed(12'(p)) - 12'sd54;
        if (fused_q) begin
          sr = {1'b0, sg} + {24'd0, g & (stk | sg[0])};
          if (sr[24]) begin
            sr = sr >> 1;
            er = er + 12'sd1;
          end
        end else begin
          sr = {1'b0, sg[23:1], sg[0] | g | stk};
        end
        if (er >= 12'sd255)
          rw = {rs, 8'hFF, 23'd0};
        else if (er <= 12'sd0)
          rw = {rs, 31'd0};
        else
          rw = {rs, er[7:0], sr[22:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      fused_q <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      w0      <= '0;
      w1      <= '0;
      elem    <= '0;
      half    <= 1'b0;
      ph      <= '0;
    end else begin
      case (st)
        IDLE: if (in_valid) begin
          a_q     <= in_a;
          b_q     <= in_b;
          res_q   <= in_acc;
          fused_q <= in_fused;
          elem    <= '0;
          half    <= 1'b0;
          ph      <= in_fused ? 2'd2 : 2'd0;
          st      <= RUN;
        end
        RUN: begin
          case (ph)
            2'd0:    w0 <= rw;
            2'd1:    w1 <= rw;
            2'd2:    w0 <= rw;
            default: res_q[elem] <= rw;
          endcase
          if (ph == 2'd3) begin
            ph   <= fused_q ? 2'd2 : 2'd0;
            half <= !half;
            if (half) elem <= elem + 2'd1;
            if (half && elem == 2'd3) st <= DONE;
          end else begin
            ph <= ph + 2'd1;
          end
        end
        default: if (out_ready) st <= IDLE;
      endcase
    end
  end

  assign in_ready  = (st == IDLE);
  assign out_valid = (st == DONE);
  assign out_res   = res_q;
endmodule

module bf16_tile_mac_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_fused,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_res
);
  logic [5:0] cnt;
  logic       mode_q, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; mode_q <= 1'b0; busy <= 1'b0;
    end else if (in_valid && in_ready) begin
      cnt <= '0; mode_q <= in_fused; busy <= 1'b1;
    end else if (busy && !out_valid) begin
      cnt <= cnt + 6'd1;
    end else if (out_valid && out_ready) begin
      busy <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_res)); // R9
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_ready |=> in_ready && !out_valid); // R9
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> cnt == (mode_q ? 6'd16 : 6'd32)); // R10

  for (genvar i = 0; i < 4; i++) begin : g_lane
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_res[32*i+23 +: 8] == 8'hFF && out_res[32*i +: 23] != 23'd0 |-> out_res[32*i +: 32] == 32'h7FC00000); // R7
    AST_NO_DENORM: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_res[32*i+23 +: 8] == 8'h00 && out_res[32*i +: 23] != 23'd0)); // R5
  end
endmodule

bind bf16_tile_mac bf16_tile_mac_chk u_chk (.*);

// File: tb/sim_bf16_tile_mac.sv
module sim_bf16_tile_mac;
  logic         clk = 1'b0;
  logic         rst_n, in_valid, in_ready, in_fused, out_valid, out_ready;
  logic [127:0] in_a, in_b, in_acc, out_res;
  int           n_chk = 0, n_fail = 0;
  bit           finished = 1'b0;

  always #5 clk = ~clk;

  bf16_tile_mac u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fused(in_fused), .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res));

  function automatic logic [15:0] i2bf(input int v);
    int m, p;
    logic [15:0] mm;
    if (v == 0) return 16'h0000;
    m = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 8; i++) if (m >= (1 << i)) p = i;
    mm = 16'(m) << (7 - p);
    return {v < 0, 8'(127 + p), mm[6:0]};
  endfunction

  function automatic logic [31:0] i2f(input int v);
    int m, p;
    logic [31:0] mm;
    if (v == 0) return 32'h0;
    m = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 24; i++) if (m >= (1 << i)) p = i;
    mm = 32'(m) << (23 - p);
    return {v < 0, 8'(127 + p), mm[22:0]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
                     input logic f, input bit noise, input int hold,
                     output logic [127:0] res, output int lat);
    @(negedge clk);
    in_a = a; in_b = b; in_acc = acc; in_fused = f; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      in_a = ~a; in_b = ~b; in_acc = ~acc; in_fused = ~f;
    end else begin
      in_valid = 1'b0;
    end
    lat = 0;
    while (!out_valid) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    res = out_res;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9 held result", {out_valid, out_res}, {1'b1, res});
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    if (noise) chk("R9 idle after release", {126'd0, in_ready, out_valid}, 128'd2);
  endtask

  task automatic spec(input string tag, input logic [63:0] arow, input logic [63:0] bcol,
                      input logic [31:0] acc, input logic f, input logic [31:0] exp);
    logic [127:0] res;
    int lat;
    run({arow, arow}, {bcol, bcol}, {4{acc}}, f, 1'b0, 0, res, lat);
    chk(tag, res, {4{exp}});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, acc, exp, res;
    int av[8], bv[8], cv[4], ev, lat;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_fused = 1'b0;
    in_a = '0; in_b = '0; in_acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset state", {126'd0, in_ready, out_valid}, 128'd2);

    // R1 R2 R10: integer sweep in both modes
    for (int f = 0; f < 2; f++) begin
      for (int t = 0; t < 40; t++) begin
        for (int i = 0; i < 8; i++) begin
          av[i] = ((t * 13 + i * 7 + t * i + f * 5) % 17) - 8;
          bv[i] = ((t * 11 + i * 5 + 3 * t * i + 2) % 17) - 8;
          a[16*i +: 16] = i2bf(av[i]);
          b[16*i +: 16] = i2bf(bv[i]);
        end
        for (int j = 0; j < 4; j++) begin
          cv[j] = ((t * 97 + j * 31 + f * 7) % 2001) - 1000;
          acc[32*j +: 32] = i2f(cv[j]);
        end
        for (int r = 0; r < 2; r++)
          for (int c = 0; c < 2; c++) begin
            ev = cv[2*r+c];
            for (int k = 0; k < 4; k++) ev += av[4*r+k] * bv[4*c+k];
            exp[32*(2*r+c) +: 32] = i2f(ev);
          end
        run(a, b, acc, f[0], t == 5, (t == 5) ? 4 : 0, res, lat);
        chk("R1 R2 integer tile", res, exp);
        chk("R10 latency", 128'(lat), (f == 1) ? 128'd16 : 128'd32);
      end
    end

    // R3 R4: pair sum 2^24 + 1
    spec("R3 round-to-odd pair sum", {16'h0, 16'h0, 16'h3F80, 16'h4580}, {16'h0, 16'h0, 16'h3F80, 16'h4580}, 32'h0, 1'b0, 32'h4B800001);
    spec("R4 nearest-even pair sum", {16'h0, 16'h0, 16'h3F80, 16'h4580}, {16'h0, 16'h0, 16'h3F80, 16'h4580}, 32'h0, 1'b1, 32'h4B800000);
    // R4 R7: +2^200 and -2^200 products
    spec("R4 exact products cancel", {16'h0, 16'h0, 16'h7180, 16'h7180}, {16'h0, 16'h0, 16'hF180, 16'h7180}, 32'h3F800000, 1'b1, 32'h3F800000);
    spec("R7 rounded products inf-inf", {16'h0, 16'h0, 16'h7180, 16'h7180}, {16'h0, 16'h0, 16'hF180, 16'h7180}, 32'h3F800000, 1'b0, 32'h7FC00000);
    // R6
    spec("R6 overflow positive", {16'h0, 16'h0, 16'h0, 16'h7180}, {16'h0, 16'h0, 16'h0, 16'h7180}, 32'h0, 1'b0, 32'h7F800000);
    spec("R6 overflow negative", {16'h0, 16'h0, 16'h0, 16'h7180}, {16'h0, 16'h0, 16'h0, 16'hF180}, 32'h0, 1'b1, 32'hFF800000);
    // R7
    spec("R7 NaN input", {16'h0, 16'h0, 16'h0, 16'h7FC1}, {16'h0, 16'h0, 16'h0, 16'h3F80}, 32'h0, 1'b1, 32'h7FC00000);
    spec("R7 NaN accumulator", 64'h0, 64'h0, 32'h7F800001, 1'b0, 32'h7FC00000);
    // R5
    spec("R5 denormal BF16 input", {16'h0, 16'h0, 16'h0, 16'h0001}, {16'h0, 16'h0, 16'h0, 16'h7F00}, 32'h3F800000, 1'b0, 32'h3F800000);
    spec("R5 denormal BF16 input fused", {16'h0, 16'h0, 16'h0, 16'h0001}, {16'h0, 16'h0, 16'h0, 16'h7F00}, 32'h3F800000, 1'b1, 32'h3F800000);
    spec("R5 denormal product", {16'h0, 16'h0, 16'h0, 16'h1C80}, {16'h0, 16'h0, 16'h0, 16'h1C80}, 32'h0, 1'b0, 32'h0);
    spec("R5 denormal product fused", {16'h0, 16'h0, 16'h0, 16'h1C80}, {16'h0, 16'h0, 16'h0, 16'h1C80}, 32'h0, 1'b1, 32'h0);
    spec("R5 denormal accumulator", 64'h0, 64'h0, 32'h00000001, 1'b0, 32'h0);
    // R8
    spec("R8 cancellation", {16'h0, 16'h0, 16'h0, 16'hBF80}, {16'h0, 16'h0, 16'h0, 16'h3F80}, 32'h3F800000, 1'b0, 32'h0);
    spec("R8 negative zeros", {4{16'h8000}}, {4{16'h3F80}}, 32'h80000000, 1'b0, 32'h80000000);
    spec("R8 negative zeros fused", {4{16'h8000}}, {4{16'h3F80}}, 32'h80000000, 1'b1, 32'h80000000);
    // R11: acc 2^24, each pair sums to 1
    spec("R11 order fused", {16'h0, 16'h3F80, 16'h0, 16'h3F80}, {16'h0, 16'h3F80, 16'h0, 16'h3F80}, 32'h4B800000, 1'b1, 32'h4B800000);
    spec("R11 order unfused", {16'h0, 16'h3F80, 16'h0, 16'h3F80}, {16'h0, 16'h3F80, 16'h0, 16'h3F80}, 32'h4B800000, 1'b0, 32'h4B800001);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule